// File: doc/BRIEF.md
# Power-Up Serial Memory Streamer

This block sends the contents of a 128-byte memory array out on a single data line without any command from a host. A dedicated output clock paces it. After reset the block is in transmit-only mode. It uses the first nine rising edges of the output clock to synchronize and keeps its data output disabled during them. From the tenth edge on it sends the array one byte at a time, starting at address 00h. Each byte is sent most significant bit first and is followed by one idle bit period. After the last byte the address wraps to 00h, and streaming runs on without end.

A second input carries the clock of a two-wire bus. Streaming advances only while that clock is held high. Its first falling edge hands the data line to a bidirectional two-wire slave, which lives outside this block. From then on the mode flag stays set until reset, the output enable stays low, and the output clock is ignored.

Both clock inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer and an edge detector. The array storage is outside the block: the block presents a read address and takes the byte at that address back combinationally.

Top module: `txonly_streamer`

## Requirements
- R1: After reset, `sdo_oe` is 0, `rd_addr` is 00h and `bidir_mode` is 0.
- R2: The first nine rising edges of `oclk_in` that arrive while `twclk_in` is high change nothing visible, and `sdo_oe` stays 0 throughout them.
- R3: The tenth such rising edge sets `sdo_oe` to 1 and drives `sdo` with bit 7 of the byte at address 00h.
- R4: Each byte takes nine output-clock rising edges. On edges one to eight, `sdo_oe` is 1 and `sdo` carries data bits 7 down to 0 in that order. On the ninth edge, `sdo_oe` is 0.
- R5: `rd_addr` increases by one on the ninth edge of every byte, and it wraps from 7Fh to 00h. Any change of `rd_addr` while `bidir_mode` is 0 is exactly an increment by one, modulo 128.
- R6: A falling edge on `twclk_in` sets `bidir_mode` to 1. It stays 1 until reset, even if `twclk_in` rises again. While it is 1, `sdo_oe` is 0 and `rd_addr` does not change, whatever `oclk_in` does.
- R7: While `twclk_in` is low and no falling edge of it has been seen since reset, rising edges of `oclk_in` are ignored and do not count toward the nine synchronization edges.
- R8: Outputs respond to an input edge within three system-clock cycles, counting two synchronizer flops and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both clock inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| oclk_in | input | 1 | Output clock that paces transmit-only streaming |
| twclk_in | input | 1 | Two-wire bus clock; its falling edge selects bidirectional mode |
| rd_data | input | 8 | Array byte at `rd_addr` |
| rd_addr | output | 7 | Read address into the array |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for `sdo` |
| bidir_mode | output | 1 | 1 once bidirectional two-wire mode is entered |

## Verification
The hardest state to reach from the ports is the wrap from address 7Fh to 00h. Reaching it needs the full preamble and then 128 complete nine-pulse bytes, with every bit compared along the way. The bench drives more than 130 bytes against an array pattern it computes itself, so the wrap and the restart of the pattern are both observed. The bench also starts with the two-wire clock low, to show that early output-clock edges do not shorten the preamble. Only after that does it issue the single falling edge that ends streaming for good.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_STREAM = 2'd1,
        PH_BIDIR  = 2'd2
    } phase_e;
endpackage

// File: rtl/txs_edge_sync.sv
module txs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/txs_bit_pick.sv
module txs_bit_pick #(
    parameter int DATA_W = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (idx_i == IDX_W'(i)) bit_o = byte_i[i];
        end
    end
endmodule

// File: rtl/txonly_streamer.sv
module txonly_streamer
    import txs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_PULSES = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oclk_in,
    input  logic              twclk_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              bidir_mode
);
    localparam int CNT_W = $clog2(SYNC_PULSES + DATA_W + 1);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic                sdo;
        logic                oe;
    } st_t;

    localparam st_t RST_ST = '{phase: PH_SYNC, cnt: '0, addr: '0, sdo: 1'b0, oe: 1'b0};

    st_t st_d, st_q;

    logic oclk_lvl, oclk_rise, oclk_fall;
    logic tw_lvl, tw_rise, tw_fall;
    logic [IDX_W-1:0] bit_idx;
    logic             cur_bit;

    txs_edge_sync #(.STAGES(SYNC_STAGES)) u_oclk_sync (
        .clk(clk), .rst_n(rst_n), .din(oclk_in),
        .level(oclk_lvl), .rise(oclk_rise), .fall(oclk_fall)
    );

    txs_edge_sync #(.STAGES(SYNC_STAGES)) u_tw_sync (
        .clk(clk), .rst_n(rst_n), .din(twclk_in),
        .level(tw_lvl), .rise(tw_rise), .fall(tw_fall)
    );

    // slot 0 carries the top data bit
    assign bit_idx = IDX_W'(DATA_W - 1) - st_q.cnt[IDX_W-1:0];

    txs_bit_pick #(.DATA_W(DATA_W)) u_pick (
        .byte_i(rd_data), .idx_i(bit_idx), .bit_o(cur_bit)
    );

    always_comb begin
        st_d = st_q;
        if (tw_fall && st_q.phase != PH_BIDIR) begin
            st_d.phase = PH_BIDIR;
            st_d.oe    = 1'b0;
            st_d.sdo   = 1'b0;
        end else begin
            case (st_q.phase)
                PH_SYNC: begin
                    if (oclk_rise && tw_lvl) begin
                        if (st_q.cnt == CNT_W'(SYNC_PULSES - 1)) begin
                            st_d.phase = PH_STREAM;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_STREAM: begin
                    if (oclk_rise && tw_lvl) begin
                        if (st_q.cnt < CNT_W'(DATA_W)) begin
                            st_d.oe  = 1'b1;
                            st_d.sdo = cur_bit;
                            st_d.cnt = st_q.cnt + 1'b1;
                        end else begin
                            st_d.oe   = 1'b0;
                            st_d.sdo  = 1'b0;
                            st_d.addr = st_q.addr + 1'b1;
                            st_d.cnt  = '0;
                        end
                    end
                end
                default: begin
                    st_d.oe  = 1'b0;
                    st_d.sdo = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign rd_addr    = st_q.addr;
    assign sdo        = st_q.sdo;
    assign sdo_oe     = st_q.oe;
    assign bidir_mode = (st_q.phase == PH_BIDIR);

    logic unused_ok;
    assign unused_ok = oclk_lvl ^ oclk_fall ^ tw_rise;
endmodule

// File: rtl/txonly_streamer_chk.sv
module txonly_streamer_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              sdo_oe,
    input logic              bidir_mode
);
    AST_OE_LOW_IN_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |-> !sdo_oe); // R6
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |=> bidir_mode); // R6
    AST_ADDR_FROZEN_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |=> $stable(rd_addr)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != $past(rd_addr)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R5
    AST_OE_RISE_ONLY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !bidir_mode); // R4
endmodule

bind txonly_streamer txonly_streamer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .sdo_oe(sdo_oe), .bidir_mode(bidir_mode)
);

// File: tb/txonly_streamer_tb.sv
module txonly_streamer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_OCLK  = 8;
    localparam int NBYTES     = 132;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oclk_in = 1'b0;
    logic       twclk_in = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] rd_addr;
    logic       sdo, sdo_oe, bidir_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [6:0] a);
        logic [7:0] t;
        t = {1'b0, a} * 8'd37 + 8'd5;
        return t;
    endfunction

    assign rd_data = pat(rd_addr);

    txonly_streamer u_dut (
        .clk(clk), .rst_n(rst_n), .oclk_in(oclk_in), .twclk_in(twclk_in),
        .rd_data(rd_data), .rd_addr(rd_addr), .sdo(sdo), .sdo_oe(sdo_oe),
        .bidir_mode(bidir_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // rising edge, wait out the high phase, sample, then the low phase
    task automatic pulse_and_sample();
        @(negedge clk) oclk_in = 1'b1;
        repeat (HALF_OCLK) @(negedge clk);
    endtask

    task automatic pulse_low();
        oclk_in = 1'b0;
        repeat (HALF_OCLK) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sdo_oe == 1'b0, "R1 oe", int'(sdo_oe), 0);
        chk(rd_addr == 7'd0, "R1 addr", int'(rd_addr), 0);
        chk(bidir_mode == 1'b0, "R1 mode", int'(bidir_mode), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: output-clock edges while two-wire clock is still low
        for (int i = 0; i < 5; i++) begin
            pulse_and_sample();
            chk(sdo_oe == 1'b0, "R7 oe while tw low", int'(sdo_oe), 0);
            chk(bidir_mode == 1'b0, "R7 mode", int'(bidir_mode), 0);
            pulse_low();
        end
        twclk_in = 1'b1;
        repeat (6) @(negedge clk);

        // R2: nine synchronization edges
        for (int i = 0; i < 9; i++) begin
            pulse_and_sample();
            chk(sdo_oe == 1'b0, "R2 oe during preamble", int'(sdo_oe), 0);
            chk(rd_addr == 7'd0, "R2 addr during preamble", int'(rd_addr), 0);
            pulse_low();
        end

        // R3/R4/R5: stream bytes past the wrap
        for (int b = 0; b < NBYTES; b++) begin
            logic [6:0] ea;
            logic [7:0] ev;
            ea = 7'(b);
            ev = pat(ea);
            for (int s = 0; s < 8; s++) begin
                pulse_and_sample();
                if (b == 0 && s == 0) begin
                    chk(sdo_oe == 1'b1, "R3 oe on tenth edge", int'(sdo_oe), 1);
                    chk(sdo == ev[7], "R3 msb of byte 00h", int'(sdo), int'(ev[7]));
                end else begin
                    chk(sdo_oe == 1'b1, "R4 oe on data bit", int'(sdo_oe), 1);
                    chk(sdo == ev[7-s], "R4 data bit", int'(sdo), int'(ev[7-s]));
                end
                chk(rd_addr == ea, "R5 addr held in byte", int'(rd_addr), int'(ea));
                pulse_low();
            end
            pulse_and_sample();
            chk(sdo_oe == 1'b0, "R4 idle slot oe", int'(sdo_oe), 0);
            chk(rd_addr == 7'(ea + 7'd1), "R5 addr step/wrap", int'(rd_addr), int'(7'(ea + 7'd1)));
            pulse_low();
        end

        // R6: hand over to bidirectional mode mid-byte
        pulse_and_sample();
        pulse_low();
        twclk_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(bidir_mode == 1'b1, "R6 mode set", int'(bidir_mode), 1);
        chk(sdo_oe == 1'b0, "R6 oe released", int'(sdo_oe), 0);
        begin
            logic [6:0] frozen;
            frozen = rd_addr;
            twclk_in = 1'b1;
            repeat (6) @(negedge clk);
            for (int i = 0; i < 20; i++) begin
                pulse_and_sample();
                chk(bidir_mode == 1'b1, "R6 mode sticky", int'(bidir_mode), 1);
                chk(sdo_oe == 1'b0, "R6 oe stays low", int'(sdo_oe), 0);
                chk(rd_addr == frozen, "R6 addr frozen", int'(rd_addr), int'(frozen));
                pulse_low();
            end
        end

        // R8: latency of a falling edge after reset, exactly three system clocks
        rst_n = 1'b0;
        twclk_in = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        twclk_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(bidir_mode == 1'b0, "R8 not before third clock", int'(bidir_mode), 0);
        @(negedge clk);
        chk(bidir_mode == 1'b1, "R8 set on third clock", int'(bidir_mode), 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule